// File: doc/BRIEF.md
# DSI Packet Framer

The framer turns one command at a time into a serial byte stream of display-serial-link packets. A command carries a 2-bit virtual channel, a 6-bit data type and a 16-bit field. For a long packet that field is the payload byte count. For a short packet it holds the two parameter bytes. The data type alone decides whether the packet is short or long. A long packet takes its payload from a byte stream and closes with a 16-bit checksum. Every header carries a 6-bit error-correcting code.

A command can mark itself as the last one before the link drops out of high-speed mode. When end-of-transmission insertion is enabled, the framer then appends one end-of-transmission short packet after that packet, plus a configured number of extra ones. A long packet whose count exceeds the payload buffer is refused and produces no output. Lane distribution and the physical layer sit downstream.

Top module: `dsi_pkt_framer`

## Requirements
- R1: Each packet starts with four header bytes in this order: {vc[1:0], dt[5:0]}, the 16-bit field low byte, the 16-bit field high byte, then the ECC byte. Bits 7:6 of the ECC byte are zero.
- R2: A short packet is exactly the four header bytes. Its 16-bit field is {data1, data0}, so data0 goes out second and data1 third.
- R3: A data type is long when its low nibble is 0x9, 0xA, 0xC, 0xD or 0xE; this includes 0x09 and 0x19. Every other code is short (for example 0x0B, 0x05, 0x37).
- R4: The ECC is the standard 6-bit Hamming code over the 24 header bits in transmit order, with bit 0 being bit 0 of the first header byte. The end-of-transmission header 08 0F 0F therefore gets ECC 0x01.
- R5: After its header, a long packet carries exactly wc payload bytes, taken from pay_data_i in arrival order, and then two checksum bytes, low byte first.
- R6: The checksum is CRC-16 with polynomial x^16+x^12+x^5+1, seed 0xFFFF and no final inversion, applied to each byte LSB first. With wc = 0 the checksum bytes are FF FF.
- R7: The first header byte is on out_data_o in the cycle after the command is accepted, and the header bytes follow on consecutive cycles. cmd_ready_o is low from that cycle until the cycle after the last byte of the packet, including any appended end-of-transmission packets.
- R8: While the payload is expected (pay_ready_o high) and pay_valid_i is low, out_valid_o is low and the framer does not move past the current byte.
- R9: If eotp_en_i and cmd_last_i are both high when a command is accepted, the packet is followed directly by 1 + eotp_extra_i end-of-transmission packets, each 08 0F 0F 01 (virtual channel 0, type 0x08, field 0x0F0F).
- R10: If either eotp_en_i or cmd_last_i is low at acceptance, no end-of-transmission packet follows, and no byte is emitted beyond the packet.
- R11: A long command with wc greater than MAX_PAY (256) raises cmd_reject_o in the following cycle and emits no byte, and cmd_ready_o stays high. wc = MAX_PAY is accepted.
- R12: During and just after reset, out_valid_o, pay_ready_o and cmd_reject_o are low and cmd_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Framer idle; a command is taken this cycle |
| cmd_vc_i | input | 2 | Virtual channel |
| cmd_dt_i | input | 6 | Data type |
| cmd_wc_i | input | 16 | Byte count (long) or {data1, data0} (short) |
| cmd_last_i | input | 1 | Packet ends the high-speed burst |
| eotp_en_i | input | 1 | Enable automatic end-of-transmission packets |
| eotp_extra_i | input | XTRA_W | Extra end-of-transmission packets after the first |
| cmd_reject_o | output | 1 | Previous-cycle command refused (payload too long) |
| pay_valid_i | input | 1 | Payload byte present |
| pay_data_i | input | 8 | Payload byte |
| pay_ready_o | output | 1 | Payload byte taken this cycle when valid |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |

## Verification
The header's first byte is due one cycle after acceptance, and each later header or checksum byte is due one cycle after the one before it. A payload byte leaves in the same cycle it is taken. A refusal shows on cmd_reject_o one cycle after acceptance. The bench drives inputs on the falling edge and samples 1 ns later. At that point it checks the latency of each accepted command and that stalled payload cycles are quiet. A behavioural queue predicts the byte sequence, and every valid output byte is compared against it in the cycle it appears.

// File: rtl/dsi_pkt_pkg.sv
package dsi_pkt_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_SUM} fsm_e;

  localparam logic [5:0]  DT_EOTP  = 6'h08;
  localparam logic [15:0] EOTP_WC  = 16'h0F0F;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;  // x^16+x^12+x^5+1, reflected

  // parity masks over the header in transmit order (bit 0 = first byte bit 0)
  localparam logic [23:0] ECC_MASK [6] = '{
    24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00
  };

  function automatic logic dt_is_long(logic [5:0] dt);
    case (dt[3:0])
      4'h9, 4'hA, 4'hC, 4'hD, 4'hE: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] crc16_byte(logic [15:0] crc, logic [7:0] d);
    logic [15:0] c;
    c = crc;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY_R;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/dsi_hdr_ecc.sv
module dsi_hdr_ecc
  import dsi_pkt_pkg::*;
(
  input  logic [23:0] hdr_i,
  output logic [7:0]  ecc_o
);
  logic [5:0] par;

  for (genvar g = 0; g < 6; g++) begin : g_par
    assign par[g] = ^(hdr_i & ECC_MASK[g]);
  end

  assign ecc_o = {2'b00, par};
endmodule

// File: rtl/dsi_crc16.sv
module dsi_crc16
  import dsi_pkt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= CRC_SEED;
    else if (clr_i) crc_q <= CRC_SEED;
    else if (en_i)  crc_q <= crc16_byte(crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/dsi_pkt_framer.sv
module dsi_pkt_framer
  import dsi_pkt_pkg::*;
#(
  parameter int MAX_PAY = 256,
  parameter int XTRA_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_vc_i,
  input  logic [5:0]        cmd_dt_i,
  input  logic [15:0]       cmd_wc_i,
  input  logic              cmd_last_i,
  input  logic              eotp_en_i,
  input  logic [XTRA_W-1:0] eotp_extra_i,
  output logic              cmd_reject_o,
  input  logic              pay_valid_i,
  input  logic [7:0]        pay_data_i,
  output logic              pay_ready_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o
);
  localparam int          CNT_W  = $clog2(MAX_PAY + 1);
  localparam int          EOT_W  = XTRA_W + 1;
  localparam logic [15:0] MAX_WC = 16'(MAX_PAY);

  fsm_e             state_q;
  logic [23:0]      hdr_q;     // {vc, dt, wc}
  logic             long_q;
  logic [CNT_W-1:0] rem_q;
  logic [1:0]       idx_q;
  logic [EOT_W-1:0] eot_q;
  logic             rej_q;

  logic        cmd_long, too_big, accept, start, pay_take, pkt_end;
  logic [7:0]  ecc;
  logic [15:0] crc;

  assign cmd_long = dt_is_long(cmd_dt_i);
  assign too_big  = cmd_long && (cmd_wc_i > MAX_WC);
  assign accept   = cmd_valid_i && (state_q == ST_IDLE);
  assign start    = accept && !too_big;
  assign pay_take = (state_q == ST_PAY) && pay_valid_i;
  assign pkt_end  = ((state_q == ST_HDR) && (idx_q == 2'd3) && !long_q) ||
                    ((state_q == ST_SUM) && (idx_q == 2'd1));

  dsi_hdr_ecc i_ecc (
    .hdr_i ({hdr_q[15:0], hdr_q[23:16]}),
    .ecc_o (ecc)
  );

  dsi_crc16 i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (pay_take),
    .data_i (pay_data_i),
    .crc_o  (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      long_q  <= 1'b0;
      rem_q   <= '0;
      idx_q   <= '0;
      eot_q   <= '0;
      rej_q   <= 1'b0;
    end else begin
      rej_q <= accept && too_big;
      unique case (state_q)
        ST_IDLE: if (start) begin
          hdr_q   <= {cmd_vc_i, cmd_dt_i, cmd_wc_i};
          long_q  <= cmd_long;
          rem_q   <= cmd_wc_i[CNT_W-1:0];
          idx_q   <= '0;
          eot_q   <= (eotp_en_i && cmd_last_i) ? EOT_W'(eotp_extra_i) + EOT_W'(1) : '0;
          state_q <= ST_HDR;
        end
        ST_HDR: begin
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3 && long_q)
            state_q <= (rem_q == '0) ? ST_SUM : ST_PAY;
        end
        ST_PAY: if (pay_valid_i) begin
          rem_q <= rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) state_q <= ST_SUM;
        end
        ST_SUM: idx_q <= (idx_q == 2'd1) ? 2'd0 : idx_q + 2'd1;
        default: state_q <= ST_IDLE;
      endcase
      // packet finished: chain an end-of-transmission packet or go idle
      if (pkt_end) begin
        if (eot_q != '0) begin
          eot_q   <= eot_q - EOT_W'(1);
          hdr_q   <= {2'b00, DT_EOTP, EOTP_WC};
          long_q  <= 1'b0;
          state_q <= ST_HDR;
        end else begin
          state_q <= ST_IDLE;
        end
      end
    end
  end

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = 8'h00;
    unique case (state_q)
      ST_HDR: begin
        out_valid_o = 1'b1;
        unique case (idx_q)
          2'd0:    out_data_o = hdr_q[23:16];
          2'd1:    out_data_o = hdr_q[7:0];
          2'd2:    out_data_o = hdr_q[15:8];
          default: out_data_o = ecc;
        endcase
      end
      ST_PAY: begin
        out_valid_o = pay_valid_i;
        out_data_o  = pay_data_i;
      end
      ST_SUM: begin
        out_valid_o = 1'b1;
        out_data_o  = idx_q[0] ? crc[15:8] : crc[7:0];
      end
      default: ;
    endcase
  end

  assign cmd_ready_o  = (state_q == ST_IDLE);
  assign pay_ready_o  = (state_q == ST_PAY);
  assign cmd_reject_o = rej_q;
endmodule

// File: rtl/dsi_pkt_framer_chk.sv
module dsi_pkt_framer_chk
  import dsi_pkt_pkg::*;
#(
  parameter int MAX_PAY = 256
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic        cmd_ready_o,
  input logic [5:0]  cmd_dt_i,
  input logic [15:0] cmd_wc_i,
  input logic        cmd_last_i,
  input logic        eotp_en_i,
  input logic        cmd_reject_o,
  input logic        pay_valid_i,
  input logic        pay_ready_o,
  input logic        out_valid_o
);
  logic take_ok;
  assign take_ok = cmd_valid_i && cmd_ready_o &&
                   !(dt_is_long(cmd_dt_i) && (cmd_wc_i > 16'(MAX_PAY)));

  AST_HDR_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_ok |=> (out_valid_o && !cmd_ready_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!out_valid_o && !pay_ready_o)); // R7

  AST_SHORT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_ok && !dt_is_long(cmd_dt_i) && !(eotp_en_i && cmd_last_i)) |=> ##4 cmd_ready_o); // R2

  AST_PAY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_ready_o && !pay_valid_i) |=> pay_ready_o); // R8

  AST_REJ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_reject_o |-> (cmd_ready_o && !out_valid_o)); // R11

  AST_REJ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_reject_o |-> $past(cmd_valid_i && cmd_ready_o)); // R11
endmodule

bind dsi_pkt_framer dsi_pkt_framer_chk #(.MAX_PAY(MAX_PAY)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .cmd_dt_i     (cmd_dt_i),
  .cmd_wc_i     (cmd_wc_i),
  .cmd_last_i   (cmd_last_i),
  .eotp_en_i    (eotp_en_i),
  .cmd_reject_o (cmd_reject_o),
  .pay_valid_i  (pay_valid_i),
  .pay_ready_o  (pay_ready_o),
  .out_valid_o  (out_valid_o)
);

// File: tb/test_dsi_pkt_framer.sv
`timescale 1ns/1ps
module test_dsi_pkt_framer;
  localparam int MAX_PAY = 256;
  localparam int XTRA_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [1:0]        cmd_vc = '0;
  logic [5:0]        cmd_dt = '0;
  logic [15:0]       cmd_wc = '0;
  logic              cmd_last = 1'b0;
  logic              eotp_en = 1'b0;
  logic [XTRA_W-1:0] eotp_extra = '0;
  logic              cmd_reject;
  logic              pay_valid = 1'b0;
  logic [7:0]        pay_data = '0;
  logic              pay_ready;
  logic              out_valid;
  logic [7:0]        out_data;

  always #2.5 clk = ~clk;

  dsi_pkt_framer #(.MAX_PAY(MAX_PAY), .XTRA_W(XTRA_W)) i_dsi_pkt_framer (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_vc_i(cmd_vc), .cmd_dt_i(cmd_dt), .cmd_wc_i(cmd_wc),
    .cmd_last_i(cmd_last), .eotp_en_i(eotp_en), .eotp_extra_i(eotp_extra),
    .cmd_reject_o(cmd_reject),
    .pay_valid_i(pay_valid), .pay_data_i(pay_data), .pay_ready_o(pay_ready),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mon_e;
  string      mon_t;

  function automatic void check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  // column code per header bit (transmit order), XOR of codes of set bits
  function automatic logic [7:0] ref_ecc(logic [23:0] d);
    logic [5:0] code [24] = '{6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
                              6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
                              6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B};
    logic [5:0] s = '0;
    for (int i = 0; i < 24; i++) if (d[i]) s ^= code[i];
    return {2'b00, s};
  endfunction

  // bit-reversed register form, MSB-first shift with 0x1021
  function automatic logic [15:0] ref_crc(logic [7:0] d [$]);
    logic [15:0] r = 16'hFFFF;
    logic [15:0] o;
    for (int k = 0; k < d.size(); k++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = r[15] ^ d[k][b];
        r  = r << 1;
        if (fb) r ^= 16'h1021;
      end
    for (int i = 0; i < 16; i++) o[i] = r[15-i];
    return o;
  endfunction

  function automatic bit ref_long(logic [5:0] dt);
    return dt[3:0] inside {4'h9, 4'hA, 4'hC, 4'hD, 4'hE};
  endfunction

  function automatic void push_hdr(logic [7:0] di, logic [15:0] wc, string tag);
    exp_q.push_back(di);        tag_q.push_back("R1");
    exp_q.push_back(wc[7:0]);   tag_q.push_back(tag);
    exp_q.push_back(wc[15:8]);  tag_q.push_back(tag);
    exp_q.push_back(ref_ecc({wc, di})); tag_q.push_back("R4");
  endfunction

  // byte monitor: every valid output byte must match the model queue
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10", "unexpected byte", out_data, 0);
      else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(out_data == mon_e, mon_t, "byte", out_data, mon_e);
      end
    end
  end

  task automatic send(input logic [1:0] vc, input logic [5:0] dt, input logic [15:0] wc,
                      input bit last, input bit en, input logic [XTRA_W-1:0] extra,
                      input bit gaps, input string tag);
    bit lng, rej;
    logic [7:0] pay [$];
    logic [15:0] c;
    int k, guard;
    bit gapped;
    lng = ref_long(dt);
    rej = lng && (wc > 16'(MAX_PAY));
    if (!rej) begin
      push_hdr({vc, dt}, wc, tag);
      if (lng) begin
        for (int i = 0; i < int'(wc); i++) pay.push_back(8'(i * 53 + int'(wc) * 7 + 11));
        foreach (pay[i]) begin exp_q.push_back(pay[i]); tag_q.push_back("R5"); end
        c = ref_crc(pay);
        exp_q.push_back(c[7:0]);  tag_q.push_back("R6");
        exp_q.push_back(c[15:8]); tag_q.push_back("R6");
      end
      if (en && last)
        for (int n = 0; n <= int'(extra); n++) push_hdr(8'h08, 16'h0F0F, "R9");
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_vc = vc; cmd_dt = dt; cmd_wc = wc;
    cmd_last = last; eotp_en = en; eotp_extra = extra;
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    if (rej) begin
      check(cmd_reject == 1'b1, "R11", "reject flag", cmd_reject, 1);
      check(!out_valid && cmd_ready, "R11", "quiet after reject", out_valid, 0);
    end else begin
      check(out_valid && !cmd_ready, "R7", "first byte latency", {out_valid, cmd_ready}, 2);
      check(cmd_reject == 1'b0, "R11", "no reject", cmd_reject, 0);
    end
    if (lng && !rej) begin
      k = 0; guard = 0; gapped = 1'b0;
      while (k < int'(wc) && guard < 3000) begin
        @(negedge clk); guard++;
        if (pay_ready) begin
          if (gaps && !gapped && (k % 3 == 1)) begin
            pay_valid = 1'b0; gapped = 1'b1;
            #1 check(!out_valid, "R8", "stall quiet", out_valid, 0);
          end else begin
            pay_valid = 1'b1; pay_data = pay[k]; k++; gapped = 1'b0;
          end
        end else pay_valid = 1'b0;
      end
      @(negedge clk); pay_valid = 1'b0;
    end
    guard = 0;
    while (!(cmd_ready && exp_q.size() == 0) && guard < 3000) begin
      @(negedge clk); #2; guard++;
    end
    repeat (3) @(negedge clk);
    #2;
    check(exp_q.size() == 0 && cmd_ready, tag, "packet drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && cmd_ready && !cmd_reject && !pay_ready, "R12", "in reset",
          {out_valid, cmd_ready, cmd_reject, pay_ready}, 4);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(!out_valid && cmd_ready && !cmd_reject && !pay_ready, "R12", "after reset",
          {out_valid, cmd_ready, cmd_reject, pay_ready}, 4);

    send(2'd1, 6'h15, 16'hAB36, 0, 0, 0, 0, "R2");   // short write, data0=36 data1=AB
    send(2'd0, 6'h01, 16'h0000, 0, 0, 0, 0, "R2");
    send(2'd3, 6'h37, 16'h0100, 0, 0, 0, 0, "R1");
    send(2'd0, 6'h39, 16'd3,    0, 0, 0, 0, "R5");
    send(2'd2, 6'h29, 16'd0,    0, 0, 0, 0, "R6");   // empty payload: FF FF
    send(2'd1, 6'h3E, 16'd7,    0, 0, 0, 1, "R8");   // payload with stalls
    send(2'd0, 6'h0E, 16'd2,    0, 0, 0, 0, "R3");
    send(2'd0, 6'h0B, 16'h0102, 0, 0, 0, 0, "R3");   // low nibble B: short
    send(2'd2, 6'h19, 16'd1,    0, 0, 0, 0, "R3");
    send(2'd3, 6'h1C, 16'd4,    0, 0, 0, 0, "R3");
    send(2'd0, 6'h21, 16'h0000, 1, 1, 2, 0, "R9");   // 3 EoTp
    send(2'd1, 6'h29, 16'd5,    1, 1, 0, 0, "R9");   // 1 EoTp after long
    send(2'd2, 6'h05, 16'h0011, 1, 1, 3, 0, "R9");   // 4 EoTp
    send(2'd0, 6'h05, 16'h0011, 1, 0, 3, 0, "R10");  // disabled
    send(2'd0, 6'h05, 16'h0022, 0, 1, 3, 0, "R10");  // not last
    send(2'd0, 6'h29, 16'd257,  1, 1, 1, 0, "R11");  // refused
    send(2'd0, 6'h29, 16'hFFFF, 0, 0, 0, 0, "R11");
    send(2'd1, 6'h39, 16'd256,  0, 0, 0, 0, "R11");  // boundary accepted
    send(2'd0, 6'h05, 16'hFFFF, 0, 0, 0, 0, "R11");  // short never refused

    check(exp_q.size() == 0, "R10", "model queue empty", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule